// File: doc/BRIEF.md
# Snapshot Frame Timing Generator

This block is the camera-side sequencer for a snapshot sensor that works integrate-then-read. Once armed by a start input, it raises frame sync to open a frame. One clock later it begins a train of one-clock line-sync pulses, one per row to be read. Frame sync stays high through the whole readout and a fixed reset interval. Frame sync then falls, which starts integration for the programmed number of clocks. A frame therefore lasts readout plus reset plus integration. If a longer frame period is requested, the block pads the end of the frame instead of cutting integration short.

All outputs are registered on the falling edge of the pixel clock, so line-sync rising edges line up with falling clock edges. The line pitch is the programmed row length, but it never drops below the time needed to shift out the active window at two samples per clock per lane. A pixel-valid flag marks the clocks in each row during which double-data-rate samples are present. An interlace setting alternates a field output between frames, and the row count follows the field. Row count, window width, lane count, row length, integration time, frame period and interlace are all captured when frame sync rises, and stay fixed for that frame.

Top module: `ftg_frame_timer`

## Requirements
- R1: While reset is high, and while the block is idle with start low, frame sync, line sync, pixel valid, busy and field are all 0. Reset is synchronous, active high, and takes effect at a falling clock edge even in the middle of a frame.
- R2: At the falling edge that samples start high in idle, frame sync and busy go to 1. The first line-sync pulse follows exactly one clock later.
- R3: Each line-sync pulse is one clock wide. The frame issues exactly its row count of pulses, spaced G clocks apart. G = max(row_clks, A+1), where A is the active-clock count of R7.
- R4: Frame sync stays high for H = 1 + N·G + RESET_CLKS clocks, where N is the row count of the frame.
- R5: Frame sync then stays low for I = max(int_clks, 1) clocks. Busy stays high from frame-sync rise until those I clocks have passed, and then goes low unless a new frame begins on that edge.
- R6: If start is high at the end of a frame, the next frame-sync rise comes exactly P = max(frame_clks, H + I) clocks after the previous rise. If start is low, the block returns to idle.
- R7: After each line-sync pulse, pixel valid is high for A consecutive clocks, starting one clock after the pulse. A = ceil(max(cols,1) / (2·L)), with lane code 0 → L=1, code 1 → L=2, codes 2 and 3 → L=4.
- R8: With interlace = 0, field is 0 and N = max(rows,1). With interlace = 1, the field takes 0 on the first frame after reset and alternates on each frame after that. Field 0 reads ceil(rows/2) rows and field 1 reads floor(rows/2) rows, with a minimum of 1. Field changes only when frame sync rises.
- R9: Configuration inputs that change after frame sync has risen have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock; all state changes on its falling edge |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Arms the generator; sampled at each frame boundary |
| cfg_rows_i | input | ROW_W | Window row count |
| cfg_cols_i | input | COL_W | Active window width in pixels |
| cfg_lanes_i | input | 2 | Lane code: 0 → 1, 1 → 2, 2/3 → 4 output lanes |
| cfg_row_clks_i | input | LINE_W | Requested row length in clocks |
| cfg_int_clks_i | input | CNT_W | Integration time in clocks |
| cfg_frame_clks_i | input | CNT_W | Requested minimum frame period in clocks |
| cfg_interlace_i | input | 1 | 1 selects interlaced readout |
| fsync_o | output | 1 | Frame sync |
| lsync_o | output | 1 | Line sync, one clock per row |
| field_o | output | 1 | Field of the current frame |
| pix_valid_o | output | 1 | Double-data-rate samples valid this clock |
| busy_o | output | 1 | High from frame-sync rise until integration ends |

## Verification
Outputs move only on falling edges, so the bench drives inputs and samples outputs on rising edges, half a clock away. When start is driven at rising edge 0, frame sync is seen at rising edge 1 and line sync i at edge 2 + i·G. Pixel valid is seen at edges 3 + i·G through 2 + i·G + A, frame sync last high at edge H, busy last high at edge H + I, and the next frame sync at edge P + 1. Each vector compares every output at every rising edge of the frame against these closed forms. The directed tests count pulses and probe single edges where the field, reset and late configuration changes take effect.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_READ,
        PH_RESET,
        PH_INTEG,
        PH_PAD
    } phase_e;

    // log2 of the samples per clock across all lanes (two per lane)
    function automatic int unsigned lane_shift(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return 3;
        endcase
    endfunction

    // clocks needed to shift out one row of the active window
    function automatic int unsigned active_clks(input int unsigned cols,
                                                input logic [1:0] code);
        int unsigned c;
        int unsigned sh;
        c  = (cols == 0) ? 1 : cols;
        sh = lane_shift(code);
        return (c + (32'd1 << sh) - 1) >> sh;
    endfunction

    // rows read in this frame, depending on interlace and field
    function automatic int unsigned row_count(input int unsigned rows,
                                              input logic interlace,
                                              input logic fld);
        int unsigned r;
        r = rows;
        if (interlace) r = fld ? (rows >> 1) : ((rows + 1) >> 1);
        return (r == 0) ? 1 : r;
    endfunction

    // line pitch: requested length, but at least one clock past the active part
    function automatic int unsigned row_gap(input int unsigned row_clks,
                                            input int unsigned act);
        return (row_clks > act) ? row_clks : act + 1;
    endfunction

endpackage

// File: rtl/ftg_cfg_latch.sv
module ftg_cfg_latch
    import ftg_pkg::*;
#(
    parameter int unsigned ROW_W      = 10,
    parameter int unsigned COL_W      = 10,
    parameter int unsigned LINE_W     = 12,
    parameter int unsigned CNT_W      = 24,
    parameter int unsigned RESET_CLKS = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic              calc_i,
    input  logic              field_nx_i,
    input  logic [ROW_W-1:0]  cfg_rows_i,
    input  logic [COL_W-1:0]  cfg_cols_i,
    input  logic [1:0]        cfg_lanes_i,
    input  logic [LINE_W-1:0] cfg_row_clks_i,
    input  logic [CNT_W-1:0]  cfg_int_clks_i,
    input  logic [CNT_W-1:0]  cfg_frame_clks_i,
    input  logic              cfg_interlace_i,
    output logic [ROW_W-1:0]  rows_q_o,
    output logic [COL_W-1:0]  act_q_o,
    output logic [LINE_W-1:0] gap_q_o,
    output logic [CNT_W-1:0]  int_q_o,
    output logic [CNT_W-1:0]  period_q_o
);

    logic [31:0]      act_w;
    logic [31:0]      gap_w;
    logic [31:0]      rows_w;
    logic [31:0]      base_w;
    logic [CNT_W-1:0] frame_q;
    logic [CNT_W-1:0] int_d;
    logic [CNT_W-1:0] period_d;

    always_comb begin
        act_w  = active_clks(32'(cfg_cols_i), cfg_lanes_i);
        gap_w  = row_gap(32'(cfg_row_clks_i), act_w);
        rows_w = row_count(32'(cfg_rows_i), cfg_interlace_i, field_nx_i);
        int_d  = (cfg_int_clks_i == '0) ? CNT_W'(1) : cfg_int_clks_i;
        base_w = 32'd1 + 32'(rows_q_o) * 32'(gap_q_o) + 32'(RESET_CLKS) + 32'(int_q_o);
        period_d = (32'(frame_q) > base_w) ? frame_q : CNT_W'(base_w);
    end

    always_ff @(negedge clk_i) begin
        if (rst_i) begin
            rows_q_o   <= ROW_W'(1);
            act_q_o    <= COL_W'(1);
            gap_q_o    <= LINE_W'(2);
            int_q_o    <= CNT_W'(1);
            frame_q    <= '0;
            period_q_o <= '0;
        end else begin
            if (load_i) begin
                rows_q_o <= ROW_W'(rows_w);
                act_q_o  <= COL_W'(act_w);
                gap_q_o  <= LINE_W'(gap_w);
                int_q_o  <= int_d;
                frame_q  <= cfg_frame_clks_i;
            end
            if (calc_i) period_q_o <= period_d;
        end
    end

endmodule

// File: rtl/ftg_phase_fsm.sv
module ftg_phase_fsm
    import ftg_pkg::*;
#(
    parameter int unsigned ROW_W      = 10,
    parameter int unsigned LINE_W     = 12,
    parameter int unsigned CNT_W      = 24,
    parameter int unsigned RESET_CLKS = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic              interlace_i,
    input  logic [ROW_W-1:0]  rows_q_i,
    input  logic [LINE_W-1:0] gap_q_i,
    input  logic [CNT_W-1:0]  int_q_i,
    input  logic [CNT_W-1:0]  period_q_i,
    output logic              load_o,
    output logic              calc_o,
    output logic              field_nx_o,
    output logic              fsync_o,
    output logic              lsync_o,
    output logic              busy_o,
    output logic              field_o
);

    localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RESET_CLKS);

    phase_e            st;
    logic [ROW_W-1:0]  rowc;
    logic [LINE_W-1:0] gcnt;
    logic [CNT_W-1:0]  pcnt;
    logic [CNT_W-1:0]  fc;
    logic              fld_tog;
    logic              int_done;
    logic              pad_done;
    logic              frame_end;

    always_comb begin
        int_done   = (st == PH_INTEG) && (pcnt == int_q_i);
        pad_done   = ({1'b0, fc} + (CNT_W+1)'(1)) >= {1'b0, period_q_i};
        frame_end  = (int_done || (st == PH_PAD)) && pad_done;
        load_o     = start_i && ((st == PH_IDLE) || frame_end);
        calc_o     = (st == PH_LEAD);
        field_nx_o = interlace_i & fld_tog;
    end

    always_ff @(negedge clk_i) begin
        if (rst_i) begin
            st      <= PH_IDLE;
            rowc    <= '0;
            gcnt    <= '0;
            pcnt    <= '0;
            fc      <= '0;
            fld_tog <= 1'b0;
            fsync_o <= 1'b0;
            lsync_o <= 1'b0;
            busy_o  <= 1'b0;
            field_o <= 1'b0;
        end else begin
            lsync_o <= 1'b0;
            fc      <= fc + CNT_W'(1);
            if (load_o) begin
                st      <= PH_LEAD;
                fc      <= '0;
                fsync_o <= 1'b1;
                busy_o  <= 1'b1;
                field_o <= field_nx_o;
                fld_tog <= interlace_i & ~fld_tog;
            end else begin
                unique case (st)
                    PH_IDLE: ;
                    PH_LEAD: begin
                        lsync_o <= 1'b1;
                        rowc    <= ROW_W'(1);
                        gcnt    <= LINE_W'(1);
                        st      <= PH_READ;
                    end
                    PH_READ: begin
                        if (gcnt == gap_q_i) begin
                            if (rowc == rows_q_i) begin
                                st   <= PH_RESET;
                                pcnt <= CNT_W'(1);
                            end else begin
                                lsync_o <= 1'b1;
                                rowc    <= rowc + ROW_W'(1);
                                gcnt    <= LINE_W'(1);
                            end
                        end else begin
                            gcnt <= gcnt + LINE_W'(1);
                        end
                    end
                    PH_RESET: begin
                        if (pcnt == RST_LAST) begin
                            fsync_o <= 1'b0;
                            st      <= PH_INTEG;
                            pcnt    <= CNT_W'(1);
                        end else begin
                            pcnt <= pcnt + CNT_W'(1);
                        end
                    end
                    PH_INTEG: begin
                        if (int_done) begin
                            busy_o <= 1'b0;
                            st     <= pad_done ? PH_IDLE : PH_PAD;
                        end else begin
                            pcnt <= pcnt + CNT_W'(1);
                        end
                    end
                    PH_PAD: begin
                        if (pad_done) st <= PH_IDLE;
                    end
                    default: st <= PH_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/ftg_pix_window.sv
module ftg_pix_window #(
    parameter int unsigned COL_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             lsync_i,
    input  logic [COL_W-1:0] act_i,
    output logic             valid_o
);

    logic [COL_W-1:0] vcnt;

    always_ff @(negedge clk_i) begin
        if (rst_i) begin
            vcnt    <= '0;
            valid_o <= 1'b0;
        end else if (lsync_i) begin
            valid_o <= 1'b1;
            vcnt    <= act_i - COL_W'(1);
        end else if (vcnt != '0) begin
            valid_o <= 1'b1;
            vcnt    <= vcnt - COL_W'(1);
        end else begin
            valid_o <= 1'b0;
        end
    end

endmodule

// File: rtl/ftg_frame_timer.sv
module ftg_frame_timer #(
    parameter int unsigned ROW_W      = 10,
    parameter int unsigned COL_W      = 10,
    parameter int unsigned LINE_W     = 12,
    parameter int unsigned CNT_W      = 24,
    parameter int unsigned RESET_CLKS = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [ROW_W-1:0]  cfg_rows_i,
    input  logic [COL_W-1:0]  cfg_cols_i,
    input  logic [1:0]        cfg_lanes_i,
    input  logic [LINE_W-1:0] cfg_row_clks_i,
    input  logic [CNT_W-1:0]  cfg_int_clks_i,
    input  logic [CNT_W-1:0]  cfg_frame_clks_i,
    input  logic              cfg_interlace_i,
    output logic              fsync_o,
    output logic              lsync_o,
    output logic              field_o,
    output logic              pix_valid_o,
    output logic              busy_o
);

    // a reset interval of zero clocks is widened to one
    localparam int unsigned RST_CLKS = (RESET_CLKS == 0) ? 1 : RESET_CLKS;

    logic              load;
    logic              calc;
    logic              field_nx;
    logic [ROW_W-1:0]  rows_q;
    logic [COL_W-1:0]  act_q;
    logic [LINE_W-1:0] gap_q;
    logic [CNT_W-1:0]  int_q;
    logic [CNT_W-1:0]  period_q;

    ftg_cfg_latch #(
        .ROW_W(ROW_W), .COL_W(COL_W), .LINE_W(LINE_W),
        .CNT_W(CNT_W), .RESET_CLKS(RST_CLKS)
    ) cfg_i (
        .clk_i           (clk_i),
        .rst_i           (rst_i),
        .load_i          (load),
        .calc_i          (calc),
        .field_nx_i      (field_nx),
        .cfg_rows_i      (cfg_rows_i),
        .cfg_cols_i      (cfg_cols_i),
        .cfg_lanes_i     (cfg_lanes_i),
        .cfg_row_clks_i  (cfg_row_clks_i),
        .cfg_int_clks_i  (cfg_int_clks_i),
        .cfg_frame_clks_i(cfg_frame_clks_i),
        .cfg_interlace_i (cfg_interlace_i),
        .rows_q_o        (rows_q),
        .act_q_o         (act_q),
        .gap_q_o         (gap_q),
        .int_q_o         (int_q),
        .period_q_o      (period_q)
    );

    ftg_phase_fsm #(
        .ROW_W(ROW_W), .LINE_W(LINE_W), .CNT_W(CNT_W), .RESET_CLKS(RST_CLKS)
    ) fsm_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .start_i    (start_i),
        .interlace_i(cfg_interlace_i),
        .rows_q_i   (rows_q),
        .gap_q_i    (gap_q),
        .int_q_i    (int_q),
        .period_q_i (period_q),
        .load_o     (load),
        .calc_o     (calc),
        .field_nx_o (field_nx),
        .fsync_o    (fsync_o),
        .lsync_o    (lsync_o),
        .busy_o     (busy_o),
        .field_o    (field_o)
    );

    ftg_pix_window #(.COL_W(COL_W)) pix_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .lsync_i(lsync_o),
        .act_i  (act_q),
        .valid_o(pix_valid_o)
    );

endmodule

// File: rtl/ftg_frame_timer_chk.sv
module ftg_frame_timer_chk (
    input logic clk_i,
    input logic rst_i,
    input logic fsync_o,
    input logic lsync_o,
    input logic field_o,
    input logic pix_valid_o,
    input logic busy_o
);

    p_first_line_r2: assert property (@(negedge clk_i) disable iff (rst_i)
        $rose(fsync_o) |=> lsync_o);

    p_busy_rise_r2: assert property (@(negedge clk_i) disable iff (rst_i)
        $rose(busy_o) |-> fsync_o);

    p_line_width_r3: assert property (@(negedge clk_i) disable iff (rst_i)
        lsync_o |=> !lsync_o);

    p_line_in_frame_r4: assert property (@(negedge clk_i) disable iff (rst_i)
        lsync_o |-> fsync_o);

    p_busy_over_frame_r5: assert property (@(negedge clk_i) disable iff (rst_i)
        fsync_o |-> busy_o);

    p_integ_busy_r5: assert property (@(negedge clk_i) disable iff (rst_i)
        $fell(fsync_o) |-> busy_o);

    p_valid_in_frame_r7: assert property (@(negedge clk_i) disable iff (rst_i)
        pix_valid_o |-> fsync_o);

    p_field_hold_r8: assert property (@(negedge clk_i) disable iff (rst_i)
        (fsync_o && $past(fsync_o)) |-> $stable(field_o));

endmodule

bind ftg_frame_timer ftg_frame_timer_chk chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .fsync_o    (fsync_o),
    .lsync_o    (lsync_o),
    .field_o    (field_o),
    .pix_valid_o(pix_valid_o),
    .busy_o     (busy_o)
);

// File: tb/ftg_frame_timer_tb_top.sv
`timescale 1ns/1ps
module ftg_frame_timer_tb_top;

    localparam int RST_CLKS = 4;
    localparam int NV = 4;
    // rows cols lanes row_clks int frame | N G A I H P
    localparam int VEC [0:NV-1][0:11] = '{
        '{3, 16, 0, 5, 10,   0, 3, 9, 8, 10, 32,  42},
        '{4, 16, 2, 6,  3, 100, 4, 6, 2,  3, 29, 100},
        '{5, 20, 1, 2,  1,   0, 5, 6, 5,  1, 35,  36},
        '{5,  7, 3, 0,  0,   0, 5, 2, 1,  1, 15,  16}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [9:0]  rows = '0;
    logic [9:0]  cols = '0;
    logic [1:0]  lanes = '0;
    logic [11:0] row_clks = '0;
    logic [23:0] int_clks = '0;
    logic [23:0] frame_clks = '0;
    logic        interlace = 1'b0;
    logic        fsync, lsync, field, pix_valid, busy;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ftg_frame_timer dut_i (
        .clk_i           (clk),
        .rst_i           (rst),
        .start_i         (start),
        .cfg_rows_i      (rows),
        .cfg_cols_i      (cols),
        .cfg_lanes_i     (lanes),
        .cfg_row_clks_i  (row_clks),
        .cfg_int_clks_i  (int_clks),
        .cfg_frame_clks_i(frame_clks),
        .cfg_interlace_i (cfg_il()),
        .fsync_o         (fsync),
        .lsync_o         (lsync),
        .field_o         (field),
        .pix_valid_o     (pix_valid),
        .busy_o          (busy)
    );

    function automatic logic cfg_il();
        return interlace;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input int r, input int c, input int l, input int rc,
                           input int ic, input int fc, input bit il);
        rows = 10'(r); cols = 10'(c); lanes = 2'(l); row_clks = 12'(rc);
        int_clks = 24'(ic); frame_clks = 24'(fc); interlace = il;
    endtask

    function automatic bit e_ls(input int j, input int n, input int g);
        return (j >= 2) && ((j - 2) % g == 0) && ((j - 2) / g < n);
    endfunction

    function automatic bit e_pv(input int j, input int n, input int g, input int a);
        return (j >= 3) && ((j - 3) / g < n) && ((j - 3) % g < a);
    endfunction

    task automatic run_vec(input int v);
        int n, g, a, ei, h, p;
        int bad_fs, bad_ls, bad_pv, bad_bz, first_fs, first_ls, first_pv, first_bz;
        n = VEC[v][6]; g = VEC[v][7]; a = VEC[v][8];
        ei = VEC[v][9]; h = VEC[v][10]; p = VEC[v][11];
        bad_fs = 0; bad_ls = 0; bad_pv = 0; bad_bz = 0;
        first_fs = 0; first_ls = 0; first_pv = 0; first_bz = 0;
        set_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], 1'b0);
        start = 1'b1;
        for (int j = 1; j <= p + 1; j++) begin
            @(posedge clk);
            if (fsync != (((j <= h) || (j == p + 1)) ? 1'b1 : 1'b0)) begin
                if (bad_fs == 0) first_fs = j;
                bad_fs++;
            end
            if (lsync != e_ls(j, n, g)) begin
                if (bad_ls == 0) first_ls = j;
                bad_ls++;
            end
            if (pix_valid != e_pv(j, n, g, a)) begin
                if (bad_pv == 0) first_pv = j;
                bad_pv++;
            end
            if (busy != (((j <= h + ei) || (j == p + 1)) ? 1'b1 : 1'b0)) begin
                if (bad_bz == 0) first_bz = j;
                bad_bz++;
            end
            if (j == 1) chk(field == 1'b0, "R8", "field without interlace", int'(field), 0);
            if (j == 2) chk(lsync && fsync, "R2", "first line one clock after frame rise",
                            int'(lsync), 1);
            if (j == p) chk(fsync == 1'b0, "R6", "frame sync low before period end", int'(fsync), 0);
            if (j == p + 1) begin
                chk(fsync == 1'b1, "R6", "next frame rise at period", int'(fsync), 1);
                start = 1'b0;
            end
        end
        chk(bad_fs == 0, "R4", $sformatf("frame sync pattern vec %0d first bad edge", v), first_fs, 0);
        chk(bad_ls == 0, "R3", $sformatf("line sync pattern vec %0d first bad edge", v), first_ls, 0);
        chk(bad_pv == 0, "R7", $sformatf("pixel valid pattern vec %0d first bad edge", v), first_pv, 0);
        chk(bad_bz == 0, "R5", $sformatf("busy pattern vec %0d first bad edge", v), first_bz, 0);
        repeat (p + 10) @(posedge clk);
    endtask

    task automatic count_lines(input int cycles, output int cnt, output int vcnt);
        cnt = 0; vcnt = 0;
        for (int j = 0; j < cycles; j++) begin
            @(posedge clk);
            if (j == 0) start = 1'b0;
            cnt  += int'(lsync);
            vcnt += int'(pix_valid);
        end
    endtask

    initial begin
        int lc, vc, act;
        repeat (3) @(posedge clk);
        // R1: reset state
        chk({fsync, lsync, pix_valid, busy, field} == 5'b0, "R1", "outputs in reset",
            int'({fsync, lsync, pix_valid, busy, field}), 0);
        rst = 1'b0;
        // R1: idle with start low
        act = 0;
        for (int j = 0; j < 20; j++) begin
            @(posedge clk);
            act += int'(fsync | lsync | busy | pix_valid);
        end
        chk(act == 0, "R1", "activity while idle", act, 0);

        for (int v = 0; v < NV; v++) run_vec(v);

        // R8: minimum row and width clamps (rows 0, cols 0 -> one row, one valid clock)
        set_cfg(0, 0, 0, 3, 1, 0, 1'b0);
        start = 1'b1;
        count_lines(9, lc, vc);
        chk(lc == 1, "R8", "line pulses with zero rows", lc, 1);
        chk(vc == 1, "R7", "valid clocks with zero width", vc, 1);
        repeat (20) @(posedge clk);

        // R8: interlaced fields, rows 5 -> 3 then 2
        set_cfg(5, 8, 2, 4, 2, 0, 1'b1);
        start = 1'b1;
        lc = 0;
        for (int j = 1; j <= 35; j++) begin
            @(posedge clk);
            if (j == 1) chk(field == 1'b0, "R8", "first interlaced field", int'(field), 0);
            if (j <= 19) lc += int'(lsync);
            if (j == 19) begin
                chk(lc == 3, "R8", "rows in field 0", lc, 3);
                lc = 0;
            end
            if (j == 20) begin
                chk(fsync && field, "R8", "second field value", int'(field), 1);
                start = 1'b0;
            end
            if (j >= 20) lc += int'(lsync);
            if (j == 35) begin
                chk(lc == 2, "R8", "rows in field 1", lc, 2);
                chk(busy == 1'b0, "R5", "busy low after field 1", int'(busy), 0);
            end
        end
        repeat (10) @(posedge clk);

        // R9: config changed after frame rise is ignored
        set_cfg(2, 8, 2, 4, 2, 0, 1'b0);
        start = 1'b1;
        lc = 0;
        for (int j = 1; j <= 16; j++) begin
            @(posedge clk);
            if (j == 1) begin
                start = 1'b0;
                set_cfg(9, 200, 0, 30, 50, 500, 1'b1);
            end
            lc += int'(lsync);
            if (j == 14) chk(fsync == 1'b0, "R9", "frame length after late change", int'(fsync), 0);
            if (j == 16) chk(busy == 1'b0, "R9", "integration after late change", int'(busy), 0);
        end
        chk(lc == 2, "R9", "row count after late change", lc, 2);
        repeat (60) @(posedge clk);

        // R1: reset in the middle of a frame
        set_cfg(4, 16, 0, 10, 20, 0, 1'b0);
        start = 1'b1;
        repeat (5) @(posedge clk);
        rst = 1'b1;
        start = 1'b0;
        @(posedge clk);
        chk({fsync, lsync, pix_valid, busy, field} == 5'b0, "R1", "outputs after mid-frame reset",
            int'({fsync, lsync, pix_valid, busy, field}), 0);
        @(posedge clk);
        rst = 1'b0;
        act = 0;
        for (int j = 0; j < 10; j++) begin
            @(posedge clk);
            act += int'(fsync | busy);
        end
        chk(act == 0, "R1", "idle after mid-frame reset", act, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule